// File: doc/BRIEF.md
# Parallel Flash Sector Programmer

This block sits on the host side of a byte-wide parallel flash and writes one 128-byte sector per request. A request carries a sector number and a flag that asks for the three-load unlock sequence to be sent before the data. When the flag is set, the sequence unlocks a software-protected part. After it accepts a request, the block pulls exactly 128 bytes from a valid/ready source. It turns each byte into one write-enable pulse, with the sector number on the upper address bits and the byte's position in the stream on the lower seven.

Every strobe width and spacing is a parameter in nanoseconds, converted to clock cycles and rounded up. The flash ends its load window if too long a gap follows a load. If the source falls far enough behind that this could happen, the block abandons the sector and flags an underrun. This avoids leaving a partly loaded sector. After the last load it releases the data bus and polls the last written location with complete read cycles. It reports completion when bit 7 of the read value equals bit 7 of the last written byte. If no match arrives within a parameterised limit, it reports a timeout.

Top module: `flash_sector_writer`

## Requirements
- R1: After reset, chip, output and write enables are high (inactive), the data bus is not driven and `req_ready` is high.
- R2: Every write-enable low pulse lasts at least ceil(WE_LOW_NS/CLK_PERIOD_NS) cycles. Every high interval between two pulses of one sector lasts at least ceil(WE_HIGH_NS/CLK_PERIOD_NS) cycles.
- R3: While write-enable is low, output-enable is high, chip-enable is low and the data bus is driven.
- R4: The k-th source byte (k = 0..127) is written at address {sector, k[6:0]}, with the sector on bits 15:7. Address and data stay stable for the whole low pulse.
- R5: With the unlock flag set, three loads come before the data: 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0. Without the flag, only the 128 data loads are issued.
- R6: Once a load has been issued, a missing source byte causes a one-cycle `err_underrun` pulse within LOAD_GAP_MAX_NS/CLK_PERIOD_NS cycles of the previous write-enable rising edge. No further write pulse follows, and the block returns to idle.
- R7: After the last load, the block polls address {sector, 0x7F} with output-enable low and the bus released. Output-enable goes high between reads, and the bus is never driven while output-enable is low.
- R8: `done` pulses for one cycle when a read returns bit 7 equal to bit 7 of the last byte written. The block then returns to idle.
- R9: If no read matches, `err_timeout` pulses once polling has lasted at least ceil(POLL_TIMEOUT_NS/CLK_PERIOD_NS) cycles, and the block returns to idle.
- R10: While a sector is in progress `req_ready` is low, and `req_valid` has no effect on the addresses written.
- R11: Exactly 128 source handshakes are accepted per completed sector, each when `src_valid` and `src_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start request, taken when `req_ready` is high |
| req_sector | input | 9 | Sector number placed on address bits 15:7 |
| req_unlock | input | 1 | Send the unlock loads first |
| req_ready | output | 1 | Block idle and able to take a request |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block waiting for the next byte |
| done | output | 1 | One-cycle pulse: sector write finished |
| err_underrun | output | 1 | One-cycle pulse: source stalled too long, sector abandoned |
| err_timeout | output | 1 | One-cycle pulse: polling limit reached |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | 16 | Flash address |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Data read from the flash |

## Verification
The bench models a flash that takes each load on the rising edge of write-enable. The model returns inverted bit 7 at the last address for a chosen busy time, and it can be made to stay busy forever. A scoreboard compares every load against the expected address and data, so a design that swapped the prefix order would be caught, and so would one that counted prefix loads into the byte index or let a request arriving mid-sector change the sector. Source stalls shorter than the limit must not end the sector. A stall that is too long must produce an underrun before the load-gap deadline and no further pulse; a design that kept waiting would break that deadline. In the timeout run the flash never finishes, and the error must appear no earlier than the poll limit. Polls must also release the bus and read the last address; a design that read while driving the bus, or polled the wrong location, would be flagged.

// File: rtl/flash_sector_writer.sv
module flash_sector_writer #(
  parameter int CLK_PERIOD_NS   = 8,
  parameter int WE_LOW_NS       = 90,
  parameter int WE_HIGH_NS      = 100,
  parameter int READ_NS         = 150,
  parameter int OE_GAP_NS       = 150,
  parameter int LOAD_GAP_MAX_NS = 150000,
  parameter int POLL_TIMEOUT_NS = 12000000,
  parameter int SECTOR_BYTES    = 128,
  parameter int ADDR_W          = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0] req_sector,
  input  logic                                  req_unlock,
  output logic                                  req_ready,
  input  logic                                  src_valid,
  input  logic [7:0]                            src_data,
  output logic                                  src_ready,
  output logic                                  done,
  output logic                                  err_underrun,
  output logic                                  err_timeout,
  output logic                                  fl_ce_n,
  output logic                                  fl_oe_n,
  output logic                                  fl_we_n,
  output logic [ADDR_W-1:0]                     fl_addr,
  output logic [7:0]                            fl_dq_out,
  output logic                                  fl_dq_oe,
  input  logic [7:0]                            fl_dq_in
);

  localparam int IDX_W     = $clog2(SECTOR_BYTES);
  localparam int SEC_W     = ADDR_W - IDX_W;
  localparam int WP_CYC    = (WE_LOW_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WPH_CYC   = (WE_HIGH_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RD_CYC    = (READ_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int OEG_CYC   = (OE_GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int STALL_CYC = LOAD_GAP_MAX_NS / CLK_PERIOD_NS - 2;
  localparam int POLL_CYC  = (POLL_TIMEOUT_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int PH_MAX    = (WP_CYC > WPH_CYC ? WP_CYC : WPH_CYC) > (RD_CYC > OEG_CYC ? RD_CYC : OEG_CYC) ?
                             (WP_CYC > WPH_CYC ? WP_CYC : WPH_CYC) : (RD_CYC > OEG_CYC ? RD_CYC : OEG_CYC);
  localparam int PH_W      = $clog2(PH_MAX + 1);
  localparam int GAP_W     = $clog2(STALL_CYC + 2);
  localparam int POLL_W    = $clog2(POLL_CYC + 2);
  localparam int LD_W      = $clog2(SECTOR_BYTES + 4);
  localparam int PFX_N     = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_PRE, S_LOW, S_HIGH, S_REL, S_RD, S_OFF
  } state_t;

  state_t             state, nstate;
  logic [PH_W-1:0]    ph_cnt;
  logic [GAP_W-1:0]   gap_cnt;
  logic [POLL_W-1:0]  poll_cnt;
  logic [LD_W-1:0]    ld_cnt;
  logic [SEC_W-1:0]   sector_q;
  logic               unlock_q, armed;
  logic [7:0]         data_q;

  logic ph_zero, pre_next, last_load, match, poll_exp, stalled;
  logic [IDX_W-1:0] byte_idx;
  logic unused_dq;

  function automatic logic [ADDR_W+7:0] prefix_load(input logic [1:0] k);
    case (k)
      2'd0:    return {ADDR_W'(16'h5555), 8'hAA};
      2'd1:    return {ADDR_W'(16'h2AAA), 8'h55};
      default: return {ADDR_W'(16'h5555), 8'hA0};
    endcase
  endfunction

  assign ph_zero   = (ph_cnt == '0);
  assign pre_next  = unlock_q && (ld_cnt < LD_W'(PFX_N));
  assign last_load = (ld_cnt == (unlock_q ? LD_W'(SECTOR_BYTES + PFX_N) : LD_W'(SECTOR_BYTES)));
  assign byte_idx  = IDX_W'(ld_cnt - (unlock_q ? LD_W'(PFX_N) : LD_W'(0)));
  assign match     = (fl_dq_in[7] == data_q[7]);
  assign poll_exp  = (poll_cnt >= POLL_W'(POLL_CYC));
  assign stalled   = armed && (gap_cnt >= GAP_W'(STALL_CYC));
  assign unused_dq = ^fl_dq_in[6:0];

  assign req_ready = (state == S_IDLE);
  assign src_ready = (state == S_WAIT);
  assign fl_dq_out = data_q;

  always_comb begin
    nstate = state;
    case (state)
      S_IDLE: if (req_valid) nstate = req_unlock ? S_PRE : S_WAIT;
      S_WAIT: if (src_valid) nstate = S_PRE;
              else if (stalled) nstate = S_IDLE;
      S_PRE:  nstate = S_LOW;
      S_LOW:  if (ph_zero) nstate = S_HIGH;
      S_HIGH: if (ph_zero) nstate = last_load ? S_REL : (pre_next ? S_PRE : S_WAIT);
      S_REL:  nstate = S_RD;
      S_RD:   if (ph_zero) nstate = (match || poll_exp) ? S_IDLE : S_OFF;
      S_OFF:  if (ph_zero) nstate = S_RD;
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      ph_cnt       <= '0;
      gap_cnt      <= '0;
      poll_cnt     <= '0;
      ld_cnt       <= '0;
      sector_q     <= '0;
      unlock_q     <= 1'b0;
      armed        <= 1'b0;
      data_q       <= '0;
      fl_addr      <= '0;
      fl_ce_n      <= 1'b1;
      fl_oe_n      <= 1'b1;
      fl_we_n      <= 1'b1;
      fl_dq_oe     <= 1'b0;
      done         <= 1'b0;
      err_underrun <= 1'b0;
      err_timeout  <= 1'b0;
    end else begin
      state    <= nstate;
      fl_ce_n  <= (nstate == S_IDLE);
      fl_we_n  <= (nstate != S_LOW);
      fl_oe_n  <= (nstate != S_RD);
      fl_dq_oe <= (nstate == S_PRE) || (nstate == S_LOW) || (nstate == S_HIGH);

      if (state != nstate) begin
        case (nstate)
          S_LOW:   ph_cnt <= PH_W'(WP_CYC - 1);
          S_HIGH:  ph_cnt <= PH_W'(WPH_CYC - 1);
          S_RD:    ph_cnt <= PH_W'(RD_CYC - 1);
          S_OFF:   ph_cnt <= PH_W'(OEG_CYC - 1);
          default: ph_cnt <= '0;
        endcase
      end else if (!ph_zero) begin
        ph_cnt <= ph_cnt - 1'b1;
      end

      if (state == S_LOW)        gap_cnt <= '0;
      else if (gap_cnt != '1)    gap_cnt <= gap_cnt + 1'b1;

      if (state == S_IDLE) begin
        armed  <= 1'b0;
        ld_cnt <= '0;
      end else if (state == S_LOW && nstate == S_HIGH) begin
        armed  <= 1'b1;
        ld_cnt <= ld_cnt + 1'b1;
      end

      if (state == S_IDLE && req_valid) begin
        sector_q <= req_sector;
        unlock_q <= req_unlock;
        if (req_unlock) {fl_addr, data_q} <= prefix_load(2'd0);
      end
      if (state == S_HIGH && nstate == S_PRE) {fl_addr, data_q} <= prefix_load(ld_cnt[1:0]);
      if (state == S_WAIT && src_valid) begin
        fl_addr <= {sector_q, byte_idx};
        data_q  <= src_data;
      end
      if (state == S_HIGH && nstate == S_REL) fl_addr <= {sector_q, {IDX_W{1'b1}}};

      if (state == S_HIGH && nstate == S_REL)   poll_cnt <= '0;
      else if ((state == S_REL || state == S_RD || state == S_OFF) && poll_cnt != '1)
        poll_cnt <= poll_cnt + 1'b1;

      done         <= (state == S_RD) && ph_zero && match;
      err_timeout  <= (state == S_RD) && ph_zero && !match && poll_exp;
      err_underrun <= (state == S_WAIT) && !src_valid && stalled;
    end
  end

  logic [PH_W:0] chk_low, chk_high;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_low  <= '0;
      chk_high <= '1;
    end else begin
      chk_low  <= fl_we_n ? '0 : chk_low + 1'b1;
      if (!fl_we_n)            chk_high <= '0;
      else if (chk_high != '1) chk_high <= chk_high + 1'b1;
    end
  end

  // R2
  we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> chk_low >= (PH_W+1)'(WP_CYC));
  // R2
  we_high_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> chk_high >= (PH_W+1)'(WPH_CYC));
  // R3
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_oe_n && fl_dq_oe && !fl_ce_n));
  // R4
  load_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_dq_oe && fl_we_n));
  // R8
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_underrun, err_timeout}));
  // R6
  underrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underrun |-> (fl_we_n && req_ready));

endmodule

// File: tb/flash_sector_writer_tb.sv
module flash_sector_writer_tb;
  localparam int CLK_NS  = 8;
  localparam int GAP_NS  = 1600;
  localparam int TO_NS   = 40000;
  localparam int E_WP    = 12;
  localparam int E_WPH   = 13;
  localparam int E_GAP   = GAP_NS / CLK_NS;
  localparam int E_POLL  = TO_NS / CLK_NS;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_unlock = 0, src_valid = 0;
  logic [8:0] req_sector = '0;
  logic [7:0] src_data = '0;
  logic req_ready, src_ready, done, err_underrun, err_timeout;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [15:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;

  always #(CLK_NS/2) clk = ~clk;

  flash_sector_writer #(.CLK_PERIOD_NS(CLK_NS), .LOAD_GAP_MAX_NS(GAP_NS),
                        .POLL_TIMEOUT_NS(TO_NS)) u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [23:0] expq[$];
  int loads = 0, reads = 0, done_cnt = 0, und_cnt = 0, to_cnt = 0;
  int last_rise_cyc = 0, low_len = 0, high_len = 1000, busy_cnt = 0, busy_len = 0;
  bit hang = 0, prev_we = 1, prev_oe = 1;
  logic [15:0] last_a = '0;
  logic [7:0] last_d = '0;

  assign fl_dq_in = (busy_cnt != 0 || hang) ? {~last_d[7], last_d[6:0] ^ 7'h15} : last_d;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor and flash model
  always @(negedge clk) if (rst_n) begin
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (prev_we && !fl_we_n) begin
      chk(high_len >= E_WPH, "R2 high gap", high_len, E_WPH);
      chk(fl_oe_n && fl_dq_oe && !fl_ce_n, "R3 strobes at load", {fl_oe_n, fl_dq_oe, fl_ce_n}, 3'b110);
      low_len = 1;
    end else if (!fl_we_n) low_len = low_len + 1;
    if (!prev_we && fl_we_n) begin
      chk(low_len >= E_WP, "R2 low width", low_len, E_WP);
      loads++;
      if (expq.size() == 0) chk(0, "R4 unexpected load", {fl_addr, fl_dq_out}, 0);
      else begin
        logic [23:0] e;
        e = expq.pop_front();
        chk({fl_addr, fl_dq_out} == e, "R4/R5 load addr+data", {fl_addr, fl_dq_out}, e);
      end
      last_a = fl_addr; last_d = fl_dq_out;
      busy_cnt <= busy_len;
      last_rise_cyc = cyc;
      high_len = 1;
    end else if (fl_we_n && high_len < 1000) high_len = high_len + 1;
    if (prev_oe && !fl_oe_n) begin
      chk(!fl_dq_oe && fl_we_n && fl_addr == last_a, "R7 poll read", {fl_dq_oe, fl_addr}, {1'b0, last_a});
      reads++;
    end
    if (done) done_cnt++;
    if (err_underrun) und_cnt++;
    if (err_timeout) to_cnt++;
    prev_we = fl_we_n; prev_oe = fl_oe_n;
  end

  always @(negedge clk) if (cyc > 150000) begin
    chk(0, "watchdog", cyc, 150000);
    finish_run();
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * seed + 8'h3C) & 8'hFF);
  endfunction

  task automatic run_sector(input logic [8:0] sec, input bit unl, input int seed,
                            input int stall, input int nsend, input bit poke);
    if (unl) begin
      expq.push_back({16'h5555, 8'hAA});
      expq.push_back({16'h2AAA, 8'h55});
      expq.push_back({16'h5555, 8'hA0});
    end
    for (int i = 0; i < nsend; i++) expq.push_back({sec, 7'(i), pat(i, seed)});
    @(negedge clk);
    req_valid = 1; req_sector = sec; req_unlock = unl;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < nsend; i++) begin
      if (poke && i == 40) begin
        chk(!req_ready, "R10 ready low while busy", req_ready, 0);
        req_valid = 1; req_sector = 9'h007; req_unlock = 1;
        @(negedge clk);
        req_valid = 0;
      end
      for (int s = 0; s < (stall ? (i * 7) % stall : 0); s++) @(negedge clk);
      src_valid = 1; src_data = pat(i, seed);
      while (!src_ready) @(negedge clk);
      @(negedge clk);
      src_valid = 0;
    end
  endtask

  task automatic wait_result();
    int base;
    base = done_cnt + und_cnt + to_cnt;
    while (done_cnt + und_cnt + to_cnt == base) @(negedge clk);
  endtask

  initial begin
    int l0, r0, d0, el;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && req_ready, "R1 reset outputs",
        {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, req_ready}, 5'b11101);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // T1: plain sector, request poke mid-stream (R10), flash busy a while
    busy_len = 300; l0 = loads; r0 = reads; d0 = done_cnt;
    run_sector(9'h003, 0, 7, 0, 128, 1);
    wait_result();
    chk(done_cnt == d0 + 1, "R8 done after match", done_cnt - d0, 1);
    chk(loads - l0 == 128, "R11 load count plain", loads - l0, 128);
    chk(expq.size() == 0, "R4 all bytes loaded", expq.size(), 0);
    chk(reads - r0 >= 2, "R7 repeated polls", reads - r0, 2);
    @(negedge clk);
    chk(req_ready && fl_ce_n, "R8 idle after done", {req_ready, fl_ce_n}, 2'b11);

    // T2: unlock prefix, top sector, source stalls below the limit
    busy_len = 500; l0 = loads; d0 = done_cnt;
    run_sector(9'h1FF, 1, 13, 30, 128, 0);
    wait_result();
    chk(done_cnt == d0 + 1, "R8 done with prefix", done_cnt - d0, 1);
    chk(und_cnt == 0, "R6 no underrun on short stalls", und_cnt, 0);
    chk(loads - l0 == 131, "R5 prefix plus data count", loads - l0, 131);
    chk(expq.size() == 0, "R5 prefix order", expq.size(), 0);

    // T3: source stops after 10 bytes
    busy_len = 50; l0 = loads;
    run_sector(9'h005, 0, 3, 0, 10, 0);
    wait_result();
    el = cyc - last_rise_cyc;
    chk(und_cnt == 1, "R6 underrun flagged", und_cnt, 1);
    chk(el <= E_GAP && el >= E_GAP - 20, "R6 underrun before deadline", el, E_GAP);
    l0 = loads;
    repeat (300) @(negedge clk);
    chk(loads == l0, "R6 no pulse after underrun", loads - l0, 0);
    chk(req_ready, "R6 back to idle", req_ready, 1);

    // T4: flash never completes
    hang = 1; busy_len = 0; d0 = done_cnt;
    run_sector(9'h0AA, 1, 5, 0, 128, 0);
    wait_result();
    el = cyc - last_rise_cyc;
    chk(to_cnt == 1 && done_cnt == d0, "R9 timeout flagged", to_cnt, 1);
    chk(el >= E_POLL && el <= E_POLL + 100, "R9 timeout window", el, E_POLL);
    @(negedge clk);
    chk(req_ready, "R9 idle after timeout", req_ready, 1);
    hang = 0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule